// File: doc/BRIEF.md
# SD Data-Line Block Receiver

This block sits on the single-bit data line of an SD card and turns each received data block into 16-bit audio samples. It runs on the card clock. While the line idles high it waits. A low level marks the start of a block. It then shifts in 512 bytes, pairs them into 256 samples, and writes each sample into an external playback memory through a plain write port made of address, data and write enable.

Write addresses run on from block to block. Successive blocks therefore land in successive quarter-regions of a 1024-entry buffer, and the fifth block lands back at the bottom. The 16 check bits that follow the data are counted but not checked. The closing bit is sampled. If it is low, a sticky framing-error flag is raised, and the samples already written stay in the buffer. A one-cycle done pulse marks the end of every block.

Top module: `sd_block_rx`

## Requirements
- R1: While the data line stays high in the idle state, no write is issued. A block begins on the first clock edge that samples the line low.
- R2: Each block yields exactly 256 writes. Each write enable lasts one clock cycle. It is high in the cycle that follows the edge that captured the last bit of the sample's second byte.
- R3: Each byte arrives most-significant bit first.
- R4: The first byte of a pair becomes sample bits [7:0], and the second byte becomes bits [15:8].
- R5: After reset, the first write goes to address 0. The address grows by one per sample and wraps modulo 1024, so blocks fill consecutive 256-entry regions.
- R6: The 16 bits that follow the data are ignored whatever their values, and no write occurs while they arrive.
- R7: `blk_done_o` is high for exactly one cycle, in the cycle after the edge that samples the closing bit. This holds whatever the closing bit's value.
- R8: A closing bit sampled low sets `frame_err_o`. The flag stays set until reset. The writes of that block still take place.
- R9: Active-low asynchronous reset returns the block to idle. It clears the bit, sample and address counters and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_dat_i | input | 1 | Serial data line, idles high |
| wr_addr_o | output | 10 | Buffer write address |
| wr_data_o | output | 16 | Packed sample |
| wr_en_o | output | 1 | Write strobe, one cycle per sample |
| blk_done_o | output | 1 | End-of-block pulse |
| frame_err_o | output | 1 | Sticky bad-closing-bit flag |

## Verification
A sample's address, data and write enable all come from the same register stage. They are due in the cycle after the clock edge that samples the sample's sixteenth data bit. The done pulse and the error flag are due in the cycle after the edge that samples the closing bit. The bench changes the line on falling edges, so each bit is taken at the next rising edge. It reads every output on the falling edge that follows, which places each comparison half a cycle after the register stage that feeds the output.

// File: rtl/sd_rx_pkg.sv
package sd_rx_pkg;
  localparam int SMP_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int BLK_SMPS = 256;
  localparam int CRC_BITS = 16;
  localparam int ADDR_W   = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_CRC,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/sd_rx_ctrl.sv
module sd_rx_ctrl
  import sd_rx_pkg::*;
#(
  parameter int SMP_W_P    = SMP_W,
  parameter int BLK_SMPS_P = BLK_SMPS,
  parameter int CRC_BITS_P = CRC_BITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dat_i,
  output logic bit_vld_o,
  output logic smp_last_o,
  output logic stop_vld_o
);
  localparam int CNT_W = $clog2(SMP_W_P > CRC_BITS_P ? SMP_W_P : CRC_BITS_P);
  localparam int SMP_CW = $clog2(BLK_SMPS_P);

  rx_state_e          state_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [SMP_CW-1:0]  smp_cnt_q;
  logic               blk_last;

  always_comb begin
    bit_vld_o  = (state_q == ST_DATA);
    smp_last_o = bit_vld_o && (bit_cnt_q == CNT_W'(SMP_W_P - 1));
    blk_last   = smp_last_o && (smp_cnt_q == SMP_CW'(BLK_SMPS_P - 1));
    stop_vld_o = (state_q == ST_STOP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      smp_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          bit_cnt_q <= '0;
          smp_cnt_q <= '0;
          if (!dat_i) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (smp_last_o) begin
            bit_cnt_q <= '0;
            smp_cnt_q <= smp_cnt_q + 1'b1;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
          if (blk_last) state_q <= ST_CRC;
        end
        ST_CRC: begin
          if (bit_cnt_q == CNT_W'(CRC_BITS_P - 1)) begin
            bit_cnt_q <= '0;
            state_q   <= ST_STOP;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_STOP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // closing bit only follows the check-bit field
  p_stop_after_crc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_vld_o |-> $past(state_q) == ST_CRC);

  // no sample completes outside the data field
  p_no_smp_in_crc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_DATA) |-> !smp_last_o);
endmodule

// File: rtl/sd_rx_pack.sv
module sd_rx_pack
  import sd_rx_pkg::*;
#(
  parameter int SMP_W_P  = SMP_W,
  parameter int BYTE_W_P = BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dat_i,
  input  logic               bit_vld_i,
  input  logic               smp_last_i,
  output logic [SMP_W_P-1:0] wr_data_o,
  output logic               wr_en_o
);
  logic [SMP_W_P-1:0] shift_q;
  logic [SMP_W_P-1:0] full_word;
  logic [SMP_W_P-1:0] sample;

  always_comb begin
    full_word = {shift_q[SMP_W_P-2:0], dat_i};
    // first byte on the wire is the low byte
    sample    = {full_word[BYTE_W_P-1:0], full_word[SMP_W_P-1:BYTE_W_P]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q   <= '0;
      wr_data_o <= '0;
      wr_en_o   <= 1'b0;
    end else begin
      if (bit_vld_i) shift_q <= full_word;
      wr_en_o <= smp_last_i;
      if (smp_last_i) wr_data_o <= sample;
    end
  end

  p_wr_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  p_low_byte_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_data_o[BYTE_W_P-1:0] == $past(shift_q[SMP_W_P-2:BYTE_W_P-1]));
endmodule

// File: rtl/sd_rx_addr.sv
module sd_rx_addr
  import sd_rx_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_last_i,
  output logic [ADDR_W_P-1:0] wr_addr_o
);
  logic [ADDR_W_P-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      wr_addr_o <= '0;
    end else if (smp_last_i) begin
      wr_addr_o <= cnt_q;
      cnt_q     <= cnt_q + 1'b1;  // wraps modulo buffer depth
    end
  end

  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_last_i |=> $stable(cnt_q));
endmodule

// File: rtl/sd_block_rx.sv
module sd_block_rx
  import sd_rx_pkg::*;
#(
  parameter int SMP_W_P    = SMP_W,
  parameter int BYTE_W_P   = BYTE_W,
  parameter int BLK_SMPS_P = BLK_SMPS,
  parameter int CRC_BITS_P = CRC_BITS,
  parameter int ADDR_W_P   = ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sd_dat_i,
  output logic [ADDR_W_P-1:0] wr_addr_o,
  output logic [SMP_W_P-1:0]  wr_data_o,
  output logic                wr_en_o,
  output logic                blk_done_o,
  output logic                frame_err_o
);
  logic bit_vld;
  logic smp_last;
  logic stop_vld;

  sd_rx_ctrl #(
    .SMP_W_P   (SMP_W_P),
    .BLK_SMPS_P(BLK_SMPS_P),
    .CRC_BITS_P(CRC_BITS_P)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dat_i     (sd_dat_i),
    .bit_vld_o (bit_vld),
    .smp_last_o(smp_last),
    .stop_vld_o(stop_vld)
  );

  sd_rx_pack #(
    .SMP_W_P (SMP_W_P),
    .BYTE_W_P(BYTE_W_P)
  ) u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dat_i     (sd_dat_i),
    .bit_vld_i (bit_vld),
    .smp_last_i(smp_last),
    .wr_data_o (wr_data_o),
    .wr_en_o   (wr_en_o)
  );

  sd_rx_addr #(
    .ADDR_W_P(ADDR_W_P)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_last_i(smp_last),
    .wr_addr_o (wr_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_done_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      blk_done_o <= stop_vld;
      if (stop_vld && !sd_dat_i) frame_err_o <= 1'b1;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done_o |=> !blk_done_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);

  p_done_no_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done_o |-> !wr_en_o);
endmodule

// File: tb/sd_block_rx_tb.sv
`timescale 1ns/1ps
module sd_block_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sd_dat = 1'b1;
  logic [9:0]  wr_addr;
  logic [15:0] wr_data;
  logic        wr_en;
  logic        blk_done;
  logic        frame_err;

  int checks = 0;
  int errors = 0;
  int exp_idx = 256;
  int exp_addr = 0;
  int wr_total = 0;
  logic [15:0] exp_mem [256];
  bit prev_wr = 1'b0;

  // {first wire byte, second wire byte, expected sample}
  localparam logic [31:0] VEC [8] = '{
    {8'h00, 8'h00, 16'h0000},
    {8'hFF, 8'hFF, 16'hFFFF},
    {8'h01, 8'h80, 16'h8001},
    {8'h80, 8'h01, 16'h0180},
    {8'hA5, 8'h3C, 16'h3CA5},
    {8'h12, 8'h34, 16'h3412},
    {8'hFE, 8'h7F, 16'h7FFE},
    {8'h55, 8'hAA, 16'hAA55}
  };

  always #4 clk = ~clk;

  sd_block_rx u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sd_dat_i   (sd_dat),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .wr_en_o    (wr_en),
    .blk_done_o (blk_done),
    .frame_err_o(frame_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // write monitor, half a cycle after the register stage
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(wr_en && prev_wr), "R2", "write strobe longer than one cycle", 32'(wr_en), 0);
      if (wr_en) begin
        wr_total++;
        if (exp_idx >= 256) begin
          chk(1'b0, "R6", "unexpected write", 32'(wr_addr), 32'hFFFF);
        end else begin
          chk(wr_data == exp_mem[exp_idx], "R4", "sample data (R3 bit order)",
              32'(wr_data), 32'(exp_mem[exp_idx]));
          chk(wr_addr == 10'(exp_addr), "R5", "write address", 32'(wr_addr), 32'(exp_addr));
          exp_idx++;
          exp_addr = (exp_addr + 1) % 1024;
        end
      end
      prev_wr = wr_en;
    end else begin
      prev_wr = 1'b0;
    end
  end

  task automatic drive_bit(input logic b);
    sd_dat = b;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) drive_bit(b[i]);
  endtask

  // kind 0 walks the vector table, otherwise a counter pattern from base
  task automatic load_exp(input int kind, input int base);
    for (int i = 0; i < 256; i++) begin
      if (kind == 0) exp_mem[i] = VEC[i % 8][15:0];
      else exp_mem[i] = 16'(base + i * 7);
    end
    exp_idx = 0;
  endtask

  task automatic send_samples(input int kind, input int n);
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      if (kind == 0) begin
        send_byte(VEC[i % 8][31:24]);
        send_byte(VEC[i % 8][23:16]);
      end else begin
        send_byte(exp_mem[i][7:0]);
        send_byte(exp_mem[i][15:8]);
      end
    end
  endtask

  task automatic send_tail(input logic stop_v, input bit crc_zero, input bit exp_err);
    for (int i = 0; i < 16; i++) drive_bit(crc_zero ? 1'b0 : 1'($urandom));
    drive_bit(stop_v);
    chk(blk_done == 1'b1, "R7", "done pulse after closing bit", 32'(blk_done), 1);
    chk(frame_err == exp_err, "R8", "framing error flag", 32'(frame_err), 32'(exp_err));
    chk(exp_idx == 256, "R2", "writes in block", 32'(exp_idx), 256);
    sd_dat = 1'b1;
    @(negedge clk);
    chk(blk_done == 1'b0, "R7", "done pulse width", 32'(blk_done), 0);
  endtask

  task automatic send_block(input int kind, input int base, input logic stop_v,
                            input bit crc_zero, input bit exp_err);
    load_exp(kind, base);
    send_samples(kind, 256);
    send_tail(stop_v, crc_zero, exp_err);
  endtask

  task automatic check_reset_state(input string tag);
    chk(wr_en == 0 && blk_done == 0 && frame_err == 0, "R9", {tag, " strobes and flags"},
        {29'd0, wr_en, blk_done, frame_err}, 0);
    chk(wr_addr == 0 && wr_data == 0, "R9", {tag, " address and data"},
        {6'd0, wr_addr, wr_data}, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(1'b0, "R0", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int seen;
    repeat (3) @(negedge clk);
    check_reset_state("reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle high produces nothing
    seen = wr_total;
    repeat (40) drive_bit(1'b1);
    chk(wr_total == seen && blk_done == 0, "R1", "idle line writes", 32'(wr_total - seen), 0);

    // table block, zero check bits, then three counter blocks filling the buffer
    send_block(0, 0, 1'b1, 1'b1, 1'b0);
    repeat (5) drive_bit(1'b1);
    send_block(1, 16'h1000, 1'b1, 1'b0, 1'b0);
    send_block(1, 16'h2345, 1'b1, 1'b0, 1'b0);
    repeat (3) drive_bit(1'b1);
    send_block(1, 16'hF00F, 1'b1, 1'b0, 1'b0);
    chk(exp_addr == 0 && wr_addr == 10'd1023, "R5", "last address before wrap",
        32'(wr_addr), 1023);

    // R8: bad closing bit, writes of that block still checked, wrapped to region 0
    send_block(1, 16'h0BAD, 1'b0, 1'b0, 1'b1);
    chk(wr_addr == 10'd255, "R5", "wrapped block last address", 32'(wr_addr), 255);
    send_block(0, 0, 1'b1, 1'b0, 1'b1);
    chk(frame_err == 1'b1, "R8", "flag held after good block", 32'(frame_err), 1);

    // R9: reset in mid-block, then restart from address 0
    load_exp(1, 16'h7777);
    send_samples(1, 20);
    rst_n = 1'b0;
    sd_dat = 1'b1;
    @(negedge clk);
    check_reset_state("mid-block reset");
    exp_idx = 256;
    exp_addr = 0;
    rst_n = 1'b1;
    repeat (4) drive_bit(1'b1);
    send_block(1, 16'h4242, 1'b1, 1'b0, 1'b0);
    chk(wr_addr == 10'd255, "R5", "address after restart", 32'(wr_addr), 255);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule